// File: doc/BRIEF.md
# Stuck Clock Detector

This block supervises a system clock from a separate, always-running reference clock. It samples the supervised clock through a short synchronizer in the reference domain and treats any change between successive samples as evidence that the clock is alive. Each such change restarts a timeout counter. If the supervised clock sits at one level, high or low, for longer than a programmed interval (100 µs by default), the block emits a single-cycle reset request toward the chip's reset controller.

The detector is armed by an enable input. While the enable is low it cannot raise a request, and its count is held at zero, so a stale count never survives a disable. A synchronous, active-high clear returns the synchronizer and the counter to their idle state. After a request, the block stays silent until it sees the supervised clock move again or is cleared. Its only output is the request line; it drives no pad.

Top module: `clkstall_detect`

## Requirements
- R1: While `srst` is high at a reference edge, and in the cycle after it, `rst_req` is 0.
- R2: A level change of `mon_clk` is captured by a 2-stage synchronizer; the change clears the count at the second reference edge after the edge that first samples the new level, so a `mon_clk` that changes level at least once every LIMIT reference cycles never raises `rst_req`.
- R3: With `enable` high and `mon_clk` held low, `rst_req` goes to 1 after the LIMIT-th consecutive reference edge at which no change is detected, counted from the last clearing event.
- R4: The same timeout as R3 applies when `mon_clk` is held high.
- R5: `rst_req` is high for exactly one reference cycle per timeout and stays 0 afterwards until a new change of `mon_clk` is detected or the count is cleared.
- R6: While `enable` is 0, `rst_req` is 0 in the following cycle regardless of `mon_clk`.
- R7: Any reference edge with `enable` at 0 zeroes the count, so the LIMIT quiet edges of R3 restart once `enable` returns to 1.
- R8: `srst` zeroes the count and the synchronizer history; counting restarts from zero after it is released.
- R9: LIMIT equals REF_MHZ × TIMEOUT_NS / 1000 reference cycles (25000 with the defaults: 250 MHz and 100 µs).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Free-running reference clock; all state is clocked by it |
| srst | input | 1 | Synchronous active-high clear |
| mon_clk | input | 1 | Supervised clock, treated as asynchronous data |
| enable | input | 1 | 1 arms the detector; 0 holds it idle |
| rst_req | output | 1 | One-cycle reset request on timeout |

## Verification
A level change on `mon_clk` that is first sampled at reference edge t clears the count at edge t+2, and a timeout request appears on `rst_req` right after the LIMIT-th quiet enabled edge; enable and clear act at the very next edge. The bench keeps its own history of sampled `mon_clk` values and a quiet-edge integer, updated at every rising edge, and compares its predicted request against `rst_req` at every falling edge, so each result is checked in the exact cycle it is due. Scenario checks then count pulses per phase and locate the first pulse at edge LIMIT after a clear.

// File: rtl/clkstall_pkg.sv
package clkstall_pkg;

    // Reference cycles in the timeout window: MHz times ns over 1000.
    function automatic int unsigned timeout_cycles(input int unsigned ref_mhz,
                                                   input int unsigned window_ns);
        return (ref_mhz * window_ns) / 1000;
    endfunction

    // Bits needed to hold values 0..n inclusive.
    function automatic int unsigned cnt_width(input int unsigned n);
        return $clog2(n + 1);
    endfunction

endpackage

// File: rtl/clkstall_sync.sv
module clkstall_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic srst,
    input  logic mon,
    output logic toggled
);
    // Stage STAGES holds the previous synchronized sample for change detection.
    logic [STAGES:0] pipe;

    always_ff @(posedge clk) begin
        if (srst) begin
            pipe <= '0;
        end else begin
            pipe <= {pipe[STAGES-1:0], mon};
        end
    end

    assign toggled = pipe[STAGES-1] ^ pipe[STAGES];

endmodule

// File: rtl/clkstall_timer.sv
module clkstall_timer #(
    parameter int unsigned LIMIT = 25000
) (
    input  logic clk,
    input  logic srst,
    input  logic enable,
    input  logic toggled,
    output logic req
);
    localparam int unsigned CW = clkstall_pkg::cnt_width(LIMIT);
    localparam logic [CW-1:0] TOP  = CW'(LIMIT);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (srst || !enable || toggled) begin
            cnt <= '0;
            req <= 1'b0;
        end else if (cnt == LAST) begin
            cnt <= TOP;
            req <= 1'b1;
        end else if (cnt != TOP) begin
            cnt <= cnt + 1'b1;
            req <= 1'b0;
        end else begin
            req <= 1'b0;
        end
    end

    // R5
    pulse_one_cycle_chk: assert property (@(posedge clk) disable iff (srst)
        req |=> !req);

    // R6
    no_req_disabled_chk: assert property (@(posedge clk) disable iff (srst)
        !enable |=> !req);

    // R7
    count_zero_chk: assert property (@(posedge clk) disable iff (srst)
        !enable |=> (cnt == '0));

    // R3
    req_at_limit_chk: assert property (@(posedge clk) disable iff (srst)
        req |-> (cnt == TOP));

    // R2
    edge_clears_chk: assert property (@(posedge clk) disable iff (srst)
        (enable && toggled) |=> (cnt == '0 && !req));

    // R8
    clear_release_chk: assert property (@(posedge clk) disable iff (srst)
        $fell(srst) |-> (cnt == '0 && !req));

endmodule

// File: rtl/clkstall_detect.sv
module clkstall_detect #(
    parameter int unsigned REF_MHZ     = 250,
    parameter int unsigned TIMEOUT_NS  = 100000,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic ref_clk,
    input  logic srst,
    input  logic mon_clk,
    input  logic enable,
    output logic rst_req
);
    // R9
    localparam int unsigned LIMIT = clkstall_pkg::timeout_cycles(REF_MHZ, TIMEOUT_NS);

    logic toggled;

    clkstall_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (ref_clk),
        .srst    (srst),
        .mon     (mon_clk),
        .toggled (toggled)
    );

    clkstall_timer #(.LIMIT(LIMIT)) u_timer (
        .clk     (ref_clk),
        .srst    (srst),
        .enable  (enable),
        .toggled (toggled),
        .req     (rst_req)
    );

    // R1
    quiet_in_clear_chk: assert property (@(posedge ref_clk) disable iff (1'b0)
        srst |=> !rst_req);

endmodule

// File: tb/test_clkstall_detect.sv
module test_clkstall_detect;
    localparam int unsigned MHZ   = 250;
    localparam int unsigned WIN   = 160;
    localparam int          LIMIT = (MHZ * WIN) / 1000;   // R9: 40 cycles

    logic ref_clk = 1'b0;
    logic srst    = 1'b1;
    logic mon_clk = 1'b0;
    logic enable  = 1'b0;
    logic rst_req;

    always #2 ref_clk = ~ref_clk;   // 250 MHz

    clkstall_detect #(.REF_MHZ(MHZ), .TIMEOUT_NS(WIN), .SYNC_STAGES(2)) i_clkstall_detect (
        .ref_clk (ref_clk),
        .srst    (srst),
        .mon_clk (mon_clk),
        .enable  (enable),
        .rst_req (rst_req)
    );

    int    total = 0;
    int    bad   = 0;
    bit    done  = 1'b0;
    string tag   = "R1";

    // Behavioural reference: history of sampled levels plus a quiet-edge count.
    logic  hist[$] = '{1'b0, 1'b0, 1'b0};
    int    quiet   = 0;
    logic  exp_req = 1'b0;

    always @(posedge ref_clk) begin
        logic seen;
        if (srst) begin
            hist    = '{1'b0, 1'b0, 1'b0};
            quiet   = 0;
            exp_req = 1'b0;
        end else begin
            seen = (hist[1] != hist[2]);
            if (!enable || seen) begin
                quiet   = 0;
                exp_req = 1'b0;
            end else begin
                exp_req = (quiet == LIMIT - 1);
                if (quiet < LIMIT) quiet = quiet + 1;
            end
            hist.push_front(mon_clk);
            void'(hist.pop_back());
        end
    end

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", rq, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model.
    int  pulses = 0;
    logic prev_req = 1'b0;
    always @(negedge ref_clk) begin
        if (!done) begin
            chk(rst_req === exp_req, tag, int'(rst_req), int'(exp_req));
            if (rst_req === 1'b1) pulses++;
            if (prev_req === 1'b1 && rst_req === 1'b1)
                chk(1'b0, "R5 width", 1, 0);
            prev_req = rst_req;
        end
    end

    task automatic run(input int n);
        repeat (n) @(negedge ref_clk);
    endtask

    initial begin
        int first_k;
        run(3);
        tag = "R1";
        chk(rst_req === 1'b0, "R1 reset state", int'(rst_req), 0);

        // R9 / R3: stuck low from release, first pulse after edge LIMIT
        tag = "R3";
        srst = 1'b0; enable = 1'b1; pulses = 0; first_k = -1;
        for (int k = 1; k <= 3 * LIMIT; k++) begin
            @(negedge ref_clk);
            if (rst_req === 1'b1 && first_k < 0) first_k = k;
        end
        chk(first_k == LIMIT, "R9 timeout edge", first_k, LIMIT);
        chk(pulses == 1, "R3 stuck low pulses", pulses, 1);

        // R4: stuck high
        tag = "R4"; pulses = 0; mon_clk = 1'b1;
        run(3 * LIMIT);
        chk(pulses == 1, "R4 stuck high pulses", pulses, 1);

        // R5: stays quiet after firing, new change re-arms
        tag = "R5"; pulses = 0;
        run(4 * LIMIT);
        chk(pulses == 0, "R5 quiet after pulse", pulses, 0);
        mon_clk = 1'b0;
        run(2 * LIMIT);
        chk(pulses == 1, "R5 rearm after change", pulses, 1);

        // R2: toggling every LIMIT/2 and exactly every LIMIT cycles
        tag = "R2"; pulses = 0;
        for (int i = 0; i < 12; i++) begin mon_clk = ~mon_clk; run(LIMIT / 2); end
        chk(pulses == 0, "R2 fast toggle", pulses, 0);
        for (int i = 0; i < 6; i++) begin mon_clk = ~mon_clk; run(LIMIT); end
        chk(pulses == 0, "R2 toggle at limit", pulses, 0);
        run(2 * LIMIT);
        chk(pulses == 1, "R2 then stuck", pulses, 1);

        // R6: disabled never requests
        tag = "R6"; pulses = 0; enable = 1'b0; mon_clk = ~mon_clk;
        run(4 * LIMIT);
        chk(pulses == 0, "R6 disabled", pulses, 0);

        // R7: one disabled cycle restarts the count
        tag = "R7"; pulses = 0; enable = 1'b1;
        run(LIMIT - 3);
        enable = 1'b0; run(1); enable = 1'b1;
        run(LIMIT - 3);
        chk(pulses == 0, "R7 no early pulse", pulses, 0);
        run(10);
        chk(pulses == 1, "R7 pulse after restart", pulses, 1);

        // R8: clear mid-count restarts the count
        tag = "R8"; pulses = 0; mon_clk = ~mon_clk;
        run(LIMIT - 3);
        srst = 1'b1; run(1);
        chk(rst_req === 1'b0, "R1 during clear", int'(rst_req), 0);
        srst = 1'b0;
        run(LIMIT - 3);
        chk(pulses == 0, "R8 no early pulse", pulses, 0);
        run(10);
        chk(pulses == 1, "R8 pulse after clear", pulses, 1);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            done = 1'b1;
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule